// File: doc/BRIEF.md
# TDM Receive Timeslot Extractor

This block takes a serial time-division-multiplexed backplane stream, one bit per clock, with 64 eight-bit timeslots per frame. It locks onto a frame pulse, counts bits and timeslots, and turns each timeslot into a byte. A per-timeslot lookup table decides which slots are kept and labels each kept slot with a stream tag. Only bytes from kept slots are pushed to a downstream queue, one cycle after their last bit. The byte goes out with its slot number and stream tag.

Several tributaries can share the backplane. Byte-interleaved layouts put alternate slots in alternate streams. Frame-interleaved layouts put one stream in a block of slots and the next stream in the following block. Both are set up only through the table contents. The table is written one entry at a time through a simple write port. A write is held in a shadow copy and becomes active at the next frame boundary, so a frame is never decoded with a half-updated table.

The frame-alignment controller has two states. `ST_HUNT` waits for the first frame pulse and takes the transition *lock* to `ST_RUN` when it sees one. `ST_RUN` stays in place. Inside `ST_RUN` the counters advance by one of three moves:
- *wrap*: free-running from the end of slot 63 back to slot 0, with or without a pulse.
- *mid-mark*: a pulse at the end of slot 31 is tolerated.
- *realign*: a pulse anywhere else forces the next bit to slot 0, bit 0.

Top module: `tdm_slot_extractor`

## Requirements
- R1: After reset, `out_valid_o` and `ovf_o` are 0. Every table entry is unassigned (assign bit 0) in both the shadow and the active copy.
- R2: While no frame pulse has been seen since reset, no byte is emitted. The bit that follows the first pulse is bit 0 of slot 0.
- R3: A byte from a slot whose active table entry has assign bit 0 never appears at the output, whatever `out_ready_i` does.
- R4: Bits are shifted in MSB first, so the first bit of a slot is `out_data_o[7]`. `out_valid_o` is high for exactly one cycle, the cycle after the slot's eighth bit. In that cycle `out_slot_o` carries the slot index and `out_stream_o` carries the entry's stream tag.
- R5: A write (`tbl_we_i`, `tbl_addr_i`, `tbl_assign_i`, `tbl_stream_i`) made during a frame has no effect on that frame. It applies from slot 0 of the next frame.
- R6: A frame is 64 slots of 8 bits. After bit 7 of slot 63 comes bit 0 of slot 0, even if no pulse arrives. A pulse on bit 7 of slot 63 or of slot 31 does not disturb the count.
- R7: A pulse on any other bit realigns the counters, so the next bit is bit 0 of slot 0. The unfinished slot is discarded.
- R8: If `out_ready_i` is low in the eighth-bit cycle of an assigned slot, that byte is dropped and `ovf_o` becomes 1. `ovf_o` then stays 1 until reset.
- R9: `out_ready_i` low during an unassigned slot does not set `ovf_o`.
- R10: The stream tag of each slot is free. Both a byte-interleaved layout (tag alternating slot by slot) and a frame-interleaved layout (contiguous blocks per tag, with unassigned gaps) are decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one backplane bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_d_i | input | 1 | Serial backplane data |
| fp_i | input | 1 | Frame pulse, high on the last bit of a frame |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 6 | Table entry (slot) to write |
| tbl_assign_i | input | 1 | 1 = keep the slot, 0 = discard it |
| tbl_stream_i | input | 2 | Stream tag for the slot |
| out_ready_i | input | 1 | Downstream queue can accept a byte |
| out_valid_o | output | 1 | Byte present, one-cycle pulse |
| out_data_o | output | 8 | Received byte, first bit in the MSB |
| out_slot_o | output | 6 | Slot the byte came from |
| out_stream_o | output | 2 | Stream tag of that slot |
| ovf_o | output | 1 | Sticky: an assigned byte was dropped |

## Verification
The bench goes after table timing by reprogramming every entry during a live frame. A design that applied writes at once would emit bytes in that frame that the old table never allowed. It sends a pulse at the end of slot 31, a frame with no pulse at all, and a pulse in the middle of slot 10. A design that realigned on every pulse, or that stopped counting without one, would shift every later byte to the wrong slot and tag. Readiness is dropped once only on unassigned slots and once on assigned slots. This catches an overflow flag that fires on discarded slots, or a byte that is pushed anyway when no room exists.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    // Frame-alignment controller states
    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } align_state_e;

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_rx_pkg::*;
#(
    parameter  int NUM_SLOTS = 64,
    parameter  int SLOT_BITS = 8,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int BIT_W     = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_i,
    output logic [BIT_W-1:0]  bit_idx_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic              aligned_o,
    output logic              byte_end_o,
    output logic              frame_end_o
);

    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [SLOT_W-1:0] MID_SLOT  = SLOT_W'(NUM_SLOTS / 2 - 1);

    align_state_e      state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              last_bit, frame_last, mid_mark, realign;

    assign last_bit   = (bit_q == LAST_BIT);
    assign frame_last = last_bit && (slot_q == LAST_SLOT);
    assign mid_mark   = last_bit && (slot_q == MID_SLOT);
    assign realign    = (state_q == ST_RUN) && fp_i && !frame_last && !mid_mark;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (fp_i) state_d = ST_RUN;   // lock
            ST_RUN:  state_d = ST_RUN;             // wrap / mid-mark / realign
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // bit and slot counters
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_HUNT) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (realign || frame_last) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (last_bit) begin
            bit_q  <= '0;
            slot_q <= slot_q + 1'b1;
        end else begin
            bit_q  <= bit_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        bit_idx_o   = bit_q;
        slot_idx_o  = slot_q;
        aligned_o   = (state_q == ST_RUN);
        byte_end_o  = (state_q == ST_RUN) && last_bit;
        frame_end_o = ((state_q == ST_HUNT) && fp_i) ||
                      ((state_q == ST_RUN) && (frame_last || realign));
    end

    AST_LOCK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && fp_i) |=> (state_q == ST_RUN && bit_q == '0 && slot_q == '0)); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && frame_last) |=> (bit_q == '0 && slot_q == '0)); // R6
    AST_MID_MARK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mid_mark) |=> (bit_q == '0 && slot_q == MID_SLOT + 1'b1)); // R6
    AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (bit_q == '0 && slot_q == '0)); // R7

endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
    parameter  int NUM_SLOTS = 64,
    parameter  int STREAM_W  = 2,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [SLOT_W-1:0]   waddr_i,
    input  logic                wassign_i,
    input  logic [STREAM_W-1:0] wstream_i,
    input  logic                frame_end_i,
    input  logic [SLOT_W-1:0]   raddr_i,
    output logic                rd_assign_o,
    output logic [STREAM_W-1:0] rd_stream_o
);

    logic [NUM_SLOTS-1:0]               sh_asg_q, act_asg_q;
    logic [NUM_SLOTS-1:0][STREAM_W-1:0] sh_str_q, act_str_q;
    logic [NUM_SLOTS-1:0]               hit;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
        assign hit[i] = we_i && (waddr_i == SLOT_W'(i));
    end

    // shadow copy: written at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_asg_q <= '0;
            sh_str_q <= '0;
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (hit[i]) begin
                    sh_asg_q[i] <= wassign_i;
                    sh_str_q[i] <= wstream_i;
                end
            end
        end
    end

    // active copy: loaded at frame boundary, a same-cycle write is forwarded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_asg_q <= '0;
            act_str_q <= '0;
        end else if (frame_end_i) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                act_asg_q[i] <= hit[i] ? wassign_i : sh_asg_q[i];
                act_str_q[i] <= hit[i] ? wstream_i : sh_str_q[i];
            end
        end
    end

    assign rd_assign_o = act_asg_q[raddr_i];
    assign rd_stream_o = act_str_q[raddr_i];

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(act_asg_q) && $stable(act_str_q)); // R5

endmodule

// File: rtl/tdm_byte_packer.sv
module tdm_byte_packer #(
    parameter int SLOT_BITS = 8,
    parameter int SLOT_W    = 6,
    parameter int STREAM_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_d_i,
    input  logic                 byte_end_i,
    input  logic                 aligned_i,
    input  logic [SLOT_W-1:0]    slot_idx_i,
    input  logic                 ent_assign_i,
    input  logic [STREAM_W-1:0]  ent_stream_i,
    input  logic                 out_ready_i,
    output logic                 out_valid_o,
    output logic [SLOT_BITS-1:0] out_data_o,
    output logic [SLOT_W-1:0]    out_slot_o,
    output logic [STREAM_W-1:0]  out_stream_o,
    output logic                 ovf_o
);

    logic [SLOT_BITS-2:0] sh_q;
    logic [SLOT_BITS-1:0] full_byte;
    logic                 keep, push, drop;

    assign full_byte = {sh_q, ser_d_i};   // earliest bit ends up in the MSB
    assign keep      = byte_end_i && ent_assign_i;
    assign push      = keep && out_ready_i;
    assign drop      = keep && !out_ready_i;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SLOT_BITS-3:0], ser_d_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o  <= 1'b0;
            out_data_o   <= '0;
            out_slot_o   <= '0;
            out_stream_o <= '0;
            ovf_o        <= 1'b0;
        end else begin
            out_valid_o <= push;
            if (push) begin
                out_data_o   <= full_byte;
                out_slot_o   <= slot_idx_i;
                out_stream_o <= ent_stream_i;
            end
            if (drop) ovf_o <= 1'b1;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o); // R4
    AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(byte_end_i)); // R4
    AST_ONLY_ASSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(ent_assign_i)); // R3
    AST_NO_OUT_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned_i |=> !out_valid_o); // R2
    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R8

endmodule

// File: rtl/tdm_slot_extractor.sv
module tdm_slot_extractor #(
    parameter  int NUM_SLOTS = 64,
    parameter  int SLOT_BITS = 8,
    parameter  int STREAM_W  = 2,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int BIT_W     = $clog2(SLOT_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_d_i,
    input  logic                 fp_i,
    input  logic                 tbl_we_i,
    input  logic [SLOT_W-1:0]    tbl_addr_i,
    input  logic                 tbl_assign_i,
    input  logic [STREAM_W-1:0]  tbl_stream_i,
    input  logic                 out_ready_i,
    output logic                 out_valid_o,
    output logic [SLOT_BITS-1:0] out_data_o,
    output logic [SLOT_W-1:0]    out_slot_o,
    output logic [STREAM_W-1:0]  out_stream_o,
    output logic                 ovf_o
);

    logic [BIT_W-1:0]    bit_idx;
    logic [SLOT_W-1:0]   slot_idx;
    logic                aligned, byte_end, frame_end;
    logic                ent_assign;
    logic [STREAM_W-1:0] ent_stream;

    tdm_frame_timer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_BITS (SLOT_BITS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fp_i        (fp_i),
        .bit_idx_o   (bit_idx),
        .slot_idx_o  (slot_idx),
        .aligned_o   (aligned),
        .byte_end_o  (byte_end),
        .frame_end_o (frame_end)
    );

    tdm_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .STREAM_W  (STREAM_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (tbl_we_i),
        .waddr_i     (tbl_addr_i),
        .wassign_i   (tbl_assign_i),
        .wstream_i   (tbl_stream_i),
        .frame_end_i (frame_end),
        .raddr_i     (slot_idx),
        .rd_assign_o (ent_assign),
        .rd_stream_o (ent_stream)
    );

    tdm_byte_packer #(
        .SLOT_BITS (SLOT_BITS),
        .SLOT_W    (SLOT_W),
        .STREAM_W  (STREAM_W)
    ) u_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_d_i      (ser_d_i),
        .byte_end_i   (byte_end),
        .aligned_i    (aligned),
        .slot_idx_i   (slot_idx),
        .ent_assign_i (ent_assign),
        .ent_stream_i (ent_stream),
        .out_ready_i  (out_ready_i),
        .out_valid_o  (out_valid_o),
        .out_data_o   (out_data_o),
        .out_slot_o   (out_slot_o),
        .out_stream_o (out_stream_o),
        .ovf_o        (ovf_o)
    );

    AST_BYTE_ON_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end |-> (bit_idx == BIT_W'(SLOT_BITS - 1))); // R4

endmodule

// File: tb/tb_tdm_slot_extractor.sv
module tb_tdm_slot_extractor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_d_i = 1'b0, fp_i = 1'b0, tbl_we_i = 1'b0, tbl_assign_i = 1'b0;
    logic [5:0] tbl_addr_i = '0;
    logic [1:0] tbl_stream_i = '0;
    logic       out_ready_i = 1'b1;
    logic       out_valid_o, ovf_o;
    logic [7:0] out_data_o;
    logic [5:0] out_slot_o;
    logic [1:0] out_stream_o;

    always #2.5 clk = ~clk;   // 200 MHz

    tdm_slot_extractor dut (
        .clk(clk), .rst_n(rst_n), .ser_d_i(ser_d_i), .fp_i(fp_i),
        .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_assign_i(tbl_assign_i),
        .tbl_stream_i(tbl_stream_i), .out_ready_i(out_ready_i),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_slot_o(out_slot_o),
        .out_stream_o(out_stream_o), .ovf_o(ovf_o)
    );

    int checks = 0, fails = 0, frame_no = 0, cycles = 0;
    bit mon_on = 1'b1;
    bit exp_ovf = 1'b0;
    string cur_req = "R2";
    logic [15:0] exp_q[$];            // {slot[5:0], stream[1:0], data[7:0]}
    bit       act_asg[64], nxt_asg[64];
    bit [1:0] act_str[64], nxt_str[64];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on && rst_n && out_valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_req, "unexpected byte", {out_slot_o, out_stream_o, out_data_o}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check({out_slot_o, out_stream_o, out_data_o} == e, cur_req,
                      "slot/stream/data", {out_slot_o, out_stream_o, out_data_o}, e);
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    // driver: one frame (or cut frame), optional full-table programming
    task automatic send_frame(input bit do_prog, input int cut_bits, input bit end_fp,
                              input bit mid_fp, input bit [63:0] rdy_pat);
        bit [7:0] data[64];
        frame_no++;
        for (int s = 0; s < 64; s++) data[s] = 8'((s * 37 + frame_no * 11 + 5) & 255);
        for (int c = 0; c < cut_bits; c++) begin
            int s, b;
            s = c / 8;
            b = c % 8;
            @(negedge clk);
            ser_d_i      = data[s][7-b];                   // MSB first
            fp_i         = ((c == cut_bits - 1) && (cut_bits != 512 || end_fp)) ||
                           (mid_fp && c == 31 * 8 + 7);
            out_ready_i  = rdy_pat[s];
            tbl_we_i     = do_prog && (c < 64);
            tbl_addr_i   = 6'(c);
            tbl_assign_i = (c < 64) ? nxt_asg[c] : 1'b0;
            tbl_stream_i = (c < 64) ? nxt_str[c] : 2'd0;
            if (b == 7 && act_asg[s]) begin
                if (rdy_pat[s]) exp_q.push_back({6'(s), act_str[s], data[s]});
                else            exp_ovf = 1'b1;
            end
        end
        if (do_prog) begin
            for (int s = 0; s < 64; s++) begin
                act_asg[s] = nxt_asg[s];
                act_str[s] = nxt_str[s];
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_d_i = ($urandom_range(0, 1) == 1);
            fp_i = 1'b0;
            tbl_we_i = 1'b0;
        end
    endtask

    localparam bit [64-1:0] ALL_RDY = '1;

    initial begin
        bit [63:0] rdy;
        for (int s = 0; s < 64; s++) begin act_asg[s] = 0; act_str[s] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid_o == 1'b0, "R1", "valid after reset", out_valid_o, 0);
        check(ovf_o == 1'b0, "R1", "ovf after reset", ovf_o, 0);
        rst_n = 1'b1;

        // R2: random bits without a pulse yield nothing
        cur_req = "R2";
        idle(40);
        check(exp_q.size() == 0 && out_valid_o == 1'b0, "R2", "no output before pulse", out_valid_o, 0);
        @(negedge clk); fp_i = 1'b1; ser_d_i = 1'b0;    // lock pulse

        // R1/R5: table empty after reset; program byte-interleaved E1 layout during frame
        cur_req = "R5";
        for (int s = 0; s < 64; s++) begin nxt_asg[s] = 1; nxt_str[s] = 2'(s % 2); end
        send_frame(1, 512, 1, 0, ALL_RDY);
        check(exp_q.size() == 0, "R1", "no bytes with reset table", exp_q.size(), 0);

        // R10/R4: byte-interleaved E1, program byte-interleaved T1 layout
        cur_req = "R10";
        for (int s = 0; s < 64; s++) begin
            int p;
            p = (s - 2) % 8;
            nxt_asg[s] = (s >= 2) && (p < 6);
            nxt_str[s] = 2'(p % 2);
        end
        send_frame(1, 512, 1, 0, ALL_RDY);

        // R6 mid-frame pulse at slot 31; program frame-interleaved T1 layout
        cur_req = "R6";
        for (int s = 0; s < 64; s++) begin
            nxt_asg[s] = (s % 32) < 24;
            nxt_str[s] = (s < 32) ? 2'd1 : 2'd2;
        end
        send_frame(1, 512, 1, 1, ALL_RDY);

        // R6 flywheel: no pulse at frame end, then a normal frame
        send_frame(0, 512, 0, 0, ALL_RDY);
        send_frame(0, 512, 1, 0, ALL_RDY);

        // R7 misplaced pulse inside slot 10 bit 3
        cur_req = "R7";
        send_frame(0, 84, 1, 0, ALL_RDY);
        send_frame(0, 512, 1, 0, ALL_RDY);

        // R9 not ready only during unassigned slots 24..31
        cur_req = "R9";
        rdy = ALL_RDY;
        for (int s = 24; s < 32; s++) rdy[s] = 1'b0;
        send_frame(0, 512, 1, 0, rdy);
        check(ovf_o == 1'b0, "R9", "ovf on unassigned slots", ovf_o, 0);
        check(exp_ovf == 1'b0, "R9", "model ovf", exp_ovf, 0);

        // R8 not ready on assigned slots 5 and 40
        cur_req = "R8";
        rdy = ALL_RDY;
        rdy[5] = 1'b0;
        rdy[40] = 1'b0;
        send_frame(0, 512, 1, 0, rdy);
        check(ovf_o == 1'b1 && exp_ovf, "R8", "ovf after drop", ovf_o, 1);
        send_frame(0, 512, 1, 0, ALL_RDY);
        check(ovf_o == 1'b1, "R8", "ovf sticky", ovf_o, 1);

        @(negedge clk); fp_i = 1'b0; ser_d_i = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R3", "all expected bytes seen", exp_q.size(), 0);
        mon_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule